// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block divides its input clock by a programmable ratio N = B·P + A and marks the end of every division period with a pulse one input cycle wide. That pulse is meant to drive a phase comparator. The division uses a swallow scheme. A prescaler model runs at modulus P+1 for the first A prescaler cycles of a period and at modulus P for the rest. The period ends when B prescaler cycles have elapsed. The prescaler is modelled as a synchronous down-counter and not as a separate fast stage.

The prescaler pair is chosen with one select bit: 64/65 or 32/33. A power-down input stops the divider and clears it. The settings are sampled only when a period starts, so software can change them at any time and never gets a truncated or mixed period. A setting that cannot produce N = B·P + A is reported on an error output. When such a setting is present at a period boundary, the divider also stops and waits.

Top module: `swallow_div`

## Requirements
- R1: With the divider running on a fixed valid setting, `div_pulse_o` is high once every N input cycles. N = B·P + A, where P = 32 when `p_sel_i` is 1 and P = 64 when `p_sel_i` is 0.
- R2: Each output pulse is high for exactly one input cycle.
- R3: A = 0 is a valid setting and gives N = B·P. A equal to B is also valid and gives N = B·(P+1).
- R4: New values of `a_cnt_i`, `b_cnt_i` and `p_sel_i` are used only from the next period boundary. A period already running completes with the length set by the old values.
- R5: `cfg_err_o` is registered. It is 1 in the cycle after the inputs show B < 3 or B < A, and 0 in the cycle after a valid setting.
- R6: When the setting is invalid at a period boundary, the divider emits the closing pulse of that period and then no pulse at all. Once a valid setting is applied, the next rising edge loads it, and the first pulse is seen N+1 rising edges after the setting was applied.
- R7: While `pwr_dn_i` is 1, `div_pulse_o` is 0 from the next edge onward and the counters are cleared. After `pwr_dn_i` returns to 0, the first pulse is seen N+1 rising edges later.
- R8: While `rst_n` is low, both outputs are 0. After reset is released with a valid setting, the first pulse is seen at the (N+1)th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn_i | input | 1 | 1 stops and clears the divider |
| p_sel_i | input | 1 | Prescaler pair select: 0 = 64/65, 1 = 32/33 |
| a_cnt_i | input | 6 | Swallow count A |
| b_cnt_i | input | 11 | Main count B |
| div_pulse_o | output | 1 | One-cycle pulse at the end of each period |
| cfg_err_o | output | 1 | Invalid setting flag, registered |

## Verification
The output pulse is registered, so the pulse that closes a period is seen at the falling edge just after the period's last rising edge. A restart from reset, power-down or an invalid setting therefore first shows a pulse N+1 falling edges later, while steady operation shows one every N. The error flag lags its inputs by one edge, and the bench samples it at the first falling edge after a change. When a setting is changed, the bench counts one full interval at the old length before it expects the new length.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;
    localparam int SD_AW    = 6;
    localparam int SD_BW    = 11;
    localparam int SD_P_HI  = 64;
    localparam int SD_P_LO  = 32;
    localparam int SD_B_MIN = 3;
endpackage

// File: rtl/swallow_div_cfg_chk.sv
module swallow_div_cfg_chk #(
    parameter int AW    = 6,
    parameter int BW    = 11,
    parameter int B_MIN = 3
) (
    input  logic [AW-1:0] a_i,
    input  logic [BW-1:0] b_i,
    output logic          bad_o
);
    localparam int PADW = BW - AW;

    logic [BW-1:0] a_ext;

    always_comb begin
        a_ext = {{PADW{1'b0}}, a_i};
        // B must cover every swallowed cycle and reach the minimum length
        bad_o = (b_i < BW'(B_MIN)) || (b_i < a_ext);
    end
endmodule

// File: rtl/swallow_div_modsel.sv
module swallow_div_modsel #(
    parameter int P_HI = 64,
    parameter int P_LO = 32,
    parameter int PCW  = 7
) (
    input  logic           sel_lo_i,
    input  logic           swallow_i,
    output logic [PCW-1:0] preload_o
);
    // A prescaler cycle of modulus M lasts M edges: preload M-1
    always_comb begin
        if (sel_lo_i) begin
            preload_o = swallow_i ? PCW'(P_LO) : PCW'(P_LO - 1);
        end else begin
            preload_o = swallow_i ? PCW'(P_HI) : PCW'(P_HI - 1);
        end
    end
endmodule

// File: rtl/swallow_div.sv
module swallow_div
    import swallow_div_pkg::*;
#(
    parameter int AW    = SD_AW,
    parameter int BW    = SD_BW,
    parameter int P_HI  = SD_P_HI,
    parameter int P_LO  = SD_P_LO,
    parameter int B_MIN = SD_B_MIN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_dn_i,
    input  logic          p_sel_i,
    input  logic [AW-1:0] a_cnt_i,
    input  logic [BW-1:0] b_cnt_i,
    output logic          div_pulse_o,
    output logic          cfg_err_o
);
    localparam int PCW = $clog2(P_HI + 1);

    typedef struct packed {
        logic           run;
        logic           psel;
        logic [PCW-1:0] pre;
        logic [AW-1:0]  a;
        logic [BW-1:0]  b;
        logic           pulse;
        logic           err;
    } sd_state_t;

    sd_state_t st_d, st_q;

    logic           cfg_bad;
    logic [AW-1:0]  a_dec;
    logic [BW-1:0]  b_dec;
    logic [PCW-1:0] load_pre;
    logic [PCW-1:0] step_pre;

    swallow_div_cfg_chk #(.AW(AW), .BW(BW), .B_MIN(B_MIN)) u_cfg (
        .a_i   (a_cnt_i),
        .b_i   (b_cnt_i),
        .bad_o (cfg_bad)
    );

    // Modulus for the first prescaler cycle of a fresh period
    swallow_div_modsel #(.P_HI(P_HI), .P_LO(P_LO), .PCW(PCW)) u_mod_load (
        .sel_lo_i  (p_sel_i),
        .swallow_i (a_cnt_i != '0),
        .preload_o (load_pre)
    );

    // Modulus for each following prescaler cycle
    swallow_div_modsel #(.P_HI(P_HI), .P_LO(P_LO), .PCW(PCW)) u_mod_step (
        .sel_lo_i  (st_q.psel),
        .swallow_i (a_dec != '0),
        .preload_o (step_pre)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        st_d.err   = cfg_bad;
        a_dec      = (st_q.a != '0) ? st_q.a - AW'(1) : '0;
        b_dec      = st_q.b - BW'(1);

        if (pwr_dn_i) begin
            st_d.run  = 1'b0;
            st_d.psel = 1'b0;
            st_d.pre  = '0;
            st_d.a    = '0;
            st_d.b    = '0;
        end else if (!st_q.run || (st_q.pre == '0 && b_dec == '0)) begin
            // Period boundary (or idle): close period, sample new setting
            st_d.pulse = st_q.run;
            if (!cfg_bad) begin
                st_d.run  = 1'b1;
                st_d.psel = p_sel_i;
                st_d.pre  = load_pre;
                st_d.a    = a_cnt_i;
                st_d.b    = b_cnt_i;
            end else begin
                st_d.run  = 1'b0;
                st_d.psel = 1'b0;
                st_d.pre  = '0;
                st_d.a    = '0;
                st_d.b    = '0;
            end
        end else if (st_q.pre != '0) begin
            st_d.pre = st_q.pre - PCW'(1);
        end else begin
            // End of one prescaler cycle: both counts step down
            st_d.a   = a_dec;
            st_d.b   = b_dec;
            st_d.pre = step_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_pulse_o = st_q.pulse;
    assign cfg_err_o   = st_q.err;
endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk #(
    parameter int AW    = 6,
    parameter int BW    = 11,
    parameter int P_HI  = 64,
    parameter int B_MIN = 3,
    parameter int PCW   = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_dn,
    input logic [AW-1:0] a_in,
    input logic [BW-1:0] b_in,
    input logic          pulse,
    input logic          err,
    input logic          run,
    input logic [PCW-1:0] pre,
    input logic [AW-1:0] a_q,
    input logic [BW-1:0] b_q
);
    localparam int PADW = BW - AW;

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R7
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!pulse && !run));

    // R5
    cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (err == (($past(b_in) < BW'(B_MIN)) ||
                           ($past(b_in) < {{PADW{1'b0}}, $past(a_in)}))));

    // R1
    count_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((b_q != '0) && (b_q >= {{PADW{1'b0}}, a_q})));

    // R1
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pre <= PCW'(P_HI)));
endmodule

bind swallow_div swallow_div_chk #(
    .AW(AW), .BW(BW), .P_HI(P_HI), .B_MIN(B_MIN), .PCW(PCW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_dn (pwr_dn_i),
    .a_in   (a_cnt_i),
    .b_in   (b_cnt_i),
    .pulse  (div_pulse_o),
    .err    (cfg_err_o),
    .run    (st_q.run),
    .pre    (st_q.pre),
    .a_q    (st_q.a),
    .b_q    (st_q.b)
);

// File: tb/swallow_div_bench.sv
module swallow_div_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam int NVEC       = 7;
    // {p_sel, A, B, expected N}
    localparam int VEC [NVEC][4] = '{
        '{1,  3,  3,   99},
        '{1,  1,  4,  129},
        '{0,  0,  3,  192},
        '{0,  2,  5,  322},
        '{1, 63, 63, 2079},
        '{0, 10, 20, 1290},
        '{1,  0,  3,   96}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        p_sel = 1'b1;
    logic [5:0]  a_cnt = 6'd0;
    logic [10:0] b_cnt = 11'd3;
    logic        div_pulse;
    logic        cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swallow_div u_swallow_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_dn_i    (pwr_dn),
        .p_sel_i     (p_sel),
        .a_cnt_i     (a_cnt),
        .b_cnt_i     (b_cnt),
        .div_pulse_o (div_pulse),
        .cfg_err_o   (cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Falling edges counted until the pulse is seen high
    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_pulse && n < 5000);
    endtask

    initial begin
        int n;
        int prev_n;
        int hits;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 pulse in reset", int'(div_pulse), 0);
        check("R8 err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        wait_pulse(n);
        check("R8 first pulse latency", n, 97);
        prev_n = 96;

        for (int i = 0; i < NVEC; i++) begin
            p_sel = VEC[i][0][0];
            a_cnt = 6'(VEC[i][1]);
            b_cnt = 11'(VEC[i][2]);
            wait_pulse(n);
            check("R4 old period kept", n, prev_n);
            check("R5 no err on valid", int'(cfg_err), 0);
            wait_pulse(n);
            // R1 and R3 (A=0, A=B rows)
            check("R1 period", n, VEC[i][3]);
            prev_n = VEC[i][3];
        end

        @(negedge clk);
        check("R2 pulse width", int'(div_pulse), 0);

        // R5/R6: invalid setting, B below minimum
        b_cnt = 11'd2;
        a_cnt = 6'd0;
        @(negedge clk);
        check("R5 err B<3", int'(cfg_err), 1);
        wait_pulse(n);
        check("R6 closing period", n, 94);
        hits = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (div_pulse) hits++;
        end
        check("R6 idle no pulse", hits, 0);
        a_cnt = 6'd5;
        b_cnt = 11'd4;
        @(negedge clk);
        check("R5 err B<A", int'(cfg_err), 1);
        check("R6 idle B<A", int'(div_pulse), 0);
        p_sel = 1'b1;
        a_cnt = 6'd0;
        b_cnt = 11'd3;
        @(negedge clk);
        check("R5 err cleared", int'(cfg_err), 0);
        wait_pulse(n);
        check("R6 restart latency", n + 1, 97);

        // R7: power-down
        pwr_dn = 1'b1;
        hits = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (div_pulse) hits++;
        end
        check("R7 quiet in power-down", hits, 0);
        pwr_dn = 1'b0;
        wait_pulse(n);
        check("R7 restart latency", n, 97);
        wait_pulse(n);
        check("R7 period after restart", n, 96);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule